// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Transceiver

This block is a clocked-serial port that acts as the master of the link. It generates the serial clock and moves one 8-bit frame out on the data-out pin while it takes in another on the data-in pin. Software sees four small registers. The first is a data register: a write queues a byte to send, and a read returns the byte last received. The second is a control register with transmit and receive enable bits. The third is a status register with four flags: transmit data empty, receive data full, transmit end and overrun.

A transfer begins when software writes a byte while transmit is enabled. At the end of each frame the engine checks whether another byte is queued. If one is waiting, the next frame follows with no idle time. If none is waiting, the engine stops, parks the serial clock low and raises transmit end. A received byte that arrives while the previous one is still unread raises overrun, and the engine then starts no further frames until software clears that flag. Software may enter full-duplex operation only from a fully disabled, clean state.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the serial clock and data-out are 0, both enable bits are 0, and the status register reads 0x01 (transmit empty set, all other flags clear).
- R2: Register addresses are 0 for data (a write queues a transmit byte, a read returns the receive byte), 1 for control (bit 0 is transmit enable, bit 1 is receive enable) and 2 for status (bit 0 is transmit empty, bit 1 is receive full, bit 2 is transmit end, bit 3 is overrun).
- R3: A write to the data register clears transmit empty in the next cycle. When the engine is idle, transmit is enabled and overrun is 0, the queued byte moves into the shifter one cycle later and transmit empty returns to 1.
- R4: Each frame is 8 bits, sent and received MSB first. Data-out changes only while the serial clock is low or on its falling edge. Data-in is sampled on the rising edge.
- R5: The serial clock period is 2*(clk_div+1) system clock cycles.
- R6: A byte that is queued when a frame ends starts the next frame at once, with the rising edges evenly spaced across the frame boundary.
- R7: A frame that ends with transmit empty at 1 sets transmit end and stops the engine, and the serial clock then stays low.
- R8: With receive enabled, a frame that ends while receive full is 0 stores the received byte and sets receive full. A read of the data register clears receive full.
- R9: With receive enabled, a frame that ends while receive full is 1 sets overrun and leaves the stored receive byte unchanged.
- R10: While overrun is 1 no new frame starts, and a queued byte waits with transmit empty at 0 until overrun is cleared.
- R11: Writing 0 to status bit 2 or bit 3 clears transmit end or overrun. Writing 1 to either bit has no effect.
- R12: A control write that would set both enable bits, made while both are not already set, is ignored unless both enables are 0 and transmit end, receive full and overrun are all 0.
- R13: With receive disabled, completed frames leave receive full and the receive byte untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-period of the serial clock minus one, in system clocks |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (side effect on the data address only) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data, combinational from reg_addr |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle by the assertions. Data-out never moves while the serial clock is high. The clock is low whenever the engine is idle. A write to the data register always clears transmit empty. A held receive byte stays put while it is unread. No frame starts from idle while overrun is set. Every entry into full-duplex mode comes from a disabled, flag-free state. Other behaviour can only be shown by the bench scenarios, because it needs an external serial partner and elapsed time: MSB-first bit order in both directions, the exact clock period for a given divider, the gap-free second frame, overrun keeping the first byte, and a queued byte held back until overrun is cleared.

// File: rtl/ssx_pkg.sv
`timescale 1ns/1ps
package ssx_pkg;
    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_STAT = 2'd2
    } ssx_addr_e;

    localparam int STAT_TXE  = 0;
    localparam int STAT_RXF  = 1;
    localparam int STAT_TEND = 2;
    localparam int STAT_OVR  = 3;
endpackage

// File: rtl/ssx_sck_gen.sv
`timescale 1ns/1ps
// Serial clock generator: toggles sck every (half_m1+1) cycles while run is high.
module ssx_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             sck,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } gen_t;

    gen_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = run && (q.cnt == half_m1);
        if (!run) begin
            d = '0;
        end else if (tick) begin
            d.cnt = '0;
            d.sck = ~q.sck;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign rise = tick && !q.sck;
    assign fall = tick && q.sck;
endmodule

// File: rtl/ssx_shifter.sv
`timescale 1ns/1ps
// Frame shifter: MSB first, output updated on falling ticks, input taken on rising ticks.
module ssx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         reload,
    input  logic [W-1:0] reload_data,
    input  logic         rise,
    input  logic         fall,
    input  logic         miso,
    output logic         mosi,
    output logic         frame_done,
    output logic [W-1:0] rx_byte
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  tx_sr;
        logic [W-1:0]  rx_sr;
        logic [CW-1:0] cnt;
        logic          mosi;
    } sh_t;

    sh_t q, d;

    assign frame_done = rise && (q.cnt == LAST);
    assign rx_byte    = {q.rx_sr[W-2:0], miso};

    always_comb begin
        d = q;
        if (load) begin
            d.mosi  = load_data[W-1];
            d.tx_sr = load_data << 1;
            d.rx_sr = '0;
            d.cnt   = '0;
        end else begin
            if (rise) begin
                d.rx_sr = {q.rx_sr[W-2:0], miso};
                d.cnt   = frame_done ? '0 : q.cnt + 1'b1;
                if (reload) d.tx_sr = reload_data;
            end
            if (fall) begin
                d.mosi  = q.tx_sr[W-1];
                d.tx_sr = q.tx_sr << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mosi = q.mosi;
endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
// Master-mode full-duplex serial transceiver with a small register interface.
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [1:0]       reg_addr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);
    typedef struct packed {
        logic [W-1:0] txd;
        logic [W-1:0] rxd;
        logic         tx_en;
        logic         rx_en;
        logic         tx_empty;
        logic         rx_full;
        logic         tx_end;
        logic         ovr;
        logic         busy;
        logic         stopping;
    } xc_t;

    xc_t q, d;

    logic         rise, fall, frame_done;
    logic [W-1:0] rx_byte;
    logic         wr_data, wr_ctrl, wr_stat, rd_data;
    logic         start, rx_take, ovr_next, cont, guard_ok;

    assign wr_data = reg_wr_en && (reg_addr == ADDR_DATA);
    assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_CTRL);
    assign wr_stat = reg_wr_en && (reg_addr == ADDR_STAT);
    assign rd_data = reg_rd_en && (reg_addr == ADDR_DATA);

    assign start    = !q.busy && q.tx_en && !q.tx_empty && !q.ovr;
    assign rx_take  = frame_done && q.rx_en;
    assign ovr_next = q.ovr || (rx_take && q.rx_full);
    assign cont     = frame_done && !q.tx_empty && !ovr_next;
    assign guard_ok = !(reg_wdata[1:0] == 2'b11 && {q.rx_en, q.tx_en} != 2'b11)
                   || ({q.rx_en, q.tx_en} == 2'b00 && !q.tx_end && !q.rx_full && !q.ovr);

    always_comb begin
        d = q;
        if (start) begin
            d.busy     = 1'b1;
            d.tx_empty = 1'b1;
        end
        if (rd_data) d.rx_full = 1'b0;
        if (wr_stat) begin
            if (!reg_wdata[STAT_TEND]) d.tx_end = 1'b0;
            if (!reg_wdata[STAT_OVR])  d.ovr    = 1'b0;
        end
        if (frame_done) begin
            if (rx_take) begin
                if (q.rx_full) begin
                    d.ovr = 1'b1;
                end else begin
                    d.rxd     = rx_byte;
                    d.rx_full = 1'b1;
                end
            end
            if (cont) begin
                d.tx_empty = 1'b1;
            end else begin
                d.stopping = 1'b1;
                if (q.tx_empty) d.tx_end = 1'b1;
            end
        end
        if (fall && q.stopping) begin
            d.busy     = 1'b0;
            d.stopping = 1'b0;
        end
        if (wr_ctrl && guard_ok) begin
            d.tx_en = reg_wdata[0];
            d.rx_en = reg_wdata[1];
        end
        if (wr_data) begin
            d.txd      = reg_wdata;
            d.tx_empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.tx_empty <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = q.rxd;
            ADDR_CTRL: reg_rdata = {{(W-2){1'b0}}, q.rx_en, q.tx_en};
            ADDR_STAT: reg_rdata = {{(W-4){1'b0}}, q.ovr, q.tx_end, q.rx_full, q.tx_empty};
            default:   reg_rdata = '0;
        endcase
    end

    ssx_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.busy),
        .half_m1 (clk_div),
        .sck     (sck),
        .rise    (rise),
        .fall    (fall)
    );

    ssx_shifter #(.W(W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .load_data   (q.txd),
        .reload      (cont),
        .reload_data (q.txd),
        .rise        (rise),
        .fall        (fall),
        .miso        (miso),
        .mosi        (mosi),
        .frame_done  (frame_done),
        .rx_byte     (rx_byte)
    );
endmodule

// File: rtl/ssx_checker.sv
`timescale 1ns/1ps
module ssx_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sck,
    input logic         mosi,
    input logic         busy,
    input logic         tx_empty,
    input logic         rx_full,
    input logic         tx_end,
    input logic         ovr,
    input logic [1:0]   en,
    input logic [W-1:0] rxd,
    input logic         wr_tx,
    input logic         rd_clr
);
    // R4: data-out holds while the serial clock is high
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

    // R7: serial clock parked low whenever the engine is idle
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R3: a data write always leaves transmit empty cleared
    p_txe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> !tx_empty);

    // R9: an unread receive byte is never replaced
    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_clr) |=> $stable(rxd));

    // R10: no frame starts from idle while overrun is set
    p_halt_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !busy) |=> !busy);

    // R12: full-duplex entry only from a disabled, flag-free state
    p_entry_guard_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 2'b11 && $past(en) != 2'b11) |->
        ($past(en) == 2'b00 && !$past(tx_end) && !$past(rx_full) && !$past(ovr)));
endmodule

bind sync_serial_xcvr ssx_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .mosi     (mosi),
    .busy     (q.busy),
    .tx_empty (q.tx_empty),
    .rx_full  (q.rx_full),
    .tx_end   (q.tx_end),
    .ovr      (q.ovr),
    .en       ({q.rx_en, q.tx_en}),
    .rxd      (q.rxd),
    .wr_tx    (reg_wr_en && reg_addr == 2'd0),
    .rd_clr   (reg_rd_en && reg_addr == 2'd0)
);

// File: tb/tb_sync_serial_xcvr.sv
`timescale 1ns/1ps
module tb_sync_serial_xcvr;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] clk_div = 8'd1;
    logic       reg_wr_en = 0;
    logic       reg_rd_en = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       sck, mosi, miso;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // serial partner model
    logic [7:0] slv_q [0:7];
    int         slv_idx = 0;
    int         slv_bit = 0;
    logic [7:0] mon_sr = 0;
    logic [7:0] mon_b [0:7];
    int         mon_n = 0;
    int         rcount = 0;
    time        rise_t [0:63];

    always #5 clk = ~clk;

    sync_serial_xcvr #(.W(8), .DIV_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    assign miso = slv_q[slv_idx][7 - slv_bit];

    always @(posedge sck) begin
        mon_sr = {mon_sr[6:0], mosi};
        if (rcount < 64) rise_t[rcount] = $time;
        rcount++;
        if (rcount % 8 == 0 && mon_n < 8) begin
            mon_b[mon_n] = mon_sr;
            mon_n++;
        end
    end

    always @(negedge sck) begin
        if (slv_bit == 7) begin
            slv_bit = 0;
            if (slv_idx < 7) slv_idx++;
        end else begin
            slv_bit++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr_en = 1;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd_en = (a == 2'd0);
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd_en = 0;
    endtask

    task automatic wait_stat(input int b, input string req);
        logic hit;
        hit = 0;
        for (int i = 0; i < 4000 && !hit; i++) begin
            @(negedge clk);
            reg_addr = 2'd2;
            #1 hit = reg_rdata[b];
        end
        chk(req, hit, 1'b1);
    endtask

    task automatic prep(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        slv_q[0] = b0; slv_q[1] = b1; slv_q[2] = b2;
        for (int i = 3; i < 8; i++) slv_q[i] = 8'h00;
        slv_idx = 0; slv_bit = 0; rcount = 0; mon_n = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 sck", sck, 0);
        chk("R1 mosi", mosi, 0);
        rd(2'd2, v); chk("R1 status", v, 8'h01);
        rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
    endtask

    task automatic t_single;
        logic [7:0] v;
        clk_div = 8'd1;
        prep(8'hA5, 8'h00, 8'h00);
        wr(2'd1, 8'h03);
        rd(2'd1, v); chk("R12 entry from clean state", v, 8'h03);
        wr(2'd0, 8'h3C);
        reg_addr = 2'd2;
        #1 chk("R3 write clears tx empty", reg_rdata[0], 0);
        wait_stat(2, "R7 tx end raised");
        repeat (10) @(negedge clk);
        chk("R7 sck parked low", sck, 0);
        chk("R4 rise count", rcount, 8);
        chk("R4 MSB-first out", mon_b[0], 8'h3C);
        chk("R5 period div=1", rise_t[1] - rise_t[0], 40);
        rd(2'd2, v); chk("R8 status after frame", v, 8'h07);
        rd(2'd0, v); chk("R8 received byte", v, 8'hA5);
        rd(2'd2, v); chk("R8 read clears full", v, 8'h05);
        wr(2'd2, 8'hFF);
        rd(2'd2, v); chk("R11 writing 1 keeps tx end", v, 8'h05);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R11 writing 0 clears tx end", v, 8'h01);
    endtask

    task automatic t_back_to_back;
        logic [7:0] v;
        clk_div = 8'd3;
        prep(8'h11, 8'h22, 8'h00);
        wr(2'd0, 8'h5A);
        wait_stat(0, "R3 tx empty returns");
        wr(2'd0, 8'hC3);
        wait_stat(1, "R8 first byte in");
        rd(2'd0, v); chk("R8 first rx byte", v, 8'h11);
        wait_stat(2, "R7 tx end after two");
        repeat (10) @(negedge clk);
        chk("R6 rise count", rcount, 16);
        chk("R6 first out", mon_b[0], 8'h5A);
        chk("R6 second out", mon_b[1], 8'hC3);
        chk("R6 no gap at boundary", rise_t[8] - rise_t[7], 80);
        chk("R5 span div=3", rise_t[15] - rise_t[0], 1200);
        rd(2'd0, v); chk("R8 second rx byte", v, 8'h22);
        rd(2'd2, v); chk("R8 flags after two", v, 8'h05);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        clk_div = 8'd0;
        prep(8'h77, 8'h88, 8'h99);
        wr(2'd0, 8'h01);
        wait_stat(0, "R3 first accepted");
        wr(2'd0, 8'h02);
        wait_stat(2, "R7 end after overrun");
        repeat (6) @(negedge clk);
        rd(2'd2, v); chk("R9 overrun flags", v, 8'h0F);
        rd(2'd0, v); chk("R9 old byte kept", v, 8'h77);
        wr(2'd0, 8'h03);
        repeat (40) @(negedge clk);
        chk("R10 no frame during overrun", rcount, 16);
        rd(2'd2, v); chk("R10 byte still queued", v, 8'h0C);
        wr(2'd2, 8'h00);
        wait_stat(2, "R10 resumes after clear");
        repeat (6) @(negedge clk);
        chk("R10 queued byte sent", mon_b[2], 8'h03);
        rd(2'd0, v); chk("R8 third rx byte", v, 8'h99);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R11 both flags cleared", v, 8'h01);
    endtask

    task automatic t_tx_only;
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h01);
        clk_div = 8'd2;
        prep(8'h5F, 8'h00, 8'h00);
        wr(2'd0, 8'h81);
        wait_stat(2, "R7 tx-only end");
        repeat (10) @(negedge clk);
        chk("R4 tx-only out", mon_b[0], 8'h81);
        chk("R5 period div=2", rise_t[1] - rise_t[0], 60);
        rd(2'd2, v); chk("R13 no receive when disabled", v, 8'h05);
        rd(2'd0, v); chk("R13 rx byte untouched", v, 8'h99);
        wr(2'd1, 8'h03);
        rd(2'd1, v); chk("R12 direct switch ignored", v, 8'h01);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h03);
        rd(2'd1, v); chk("R12 entry blocked by tx end", v, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h03);
        rd(2'd1, v); chk("R12 entry after clean", v, 8'h03);
        rd(2'd2, v); chk("R2 status map idle", v, 8'h01);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) slv_q[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset;
        t_single;
        t_back_to_back;
        t_overrun;
        t_tx_only;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule